// File: doc/BRIEF.md
# RDS Bit Buffer with Master/Slave Serial Readout

This block sits behind an RDS demodulator and holds the decoded bit stream until a host collects it. Every decoded bit arrives with a one-cycle valid strobe and a reliability flag. The block keeps up to 128 such entries, which is roughly a tenth of a second of RDS traffic, in arrival order. It then hands them out over a two-wire serial link: a clock line and a data line.

Two pins choose how the link runs. In master mode the block drives the serial clock at a fixed, parameterised half period and shifts one bit out per period. Its status pin then shows the reliability flag of the bit on the wire. In slave mode the host drives the serial clock and the status pin becomes a ready flag. A standby setting freezes the buffer and quiets the link. A channel-reset input clears the detection state, and it also empties the buffer when the link is in slave mode. After any reset, nothing is stored until the signal-present input is first seen high.

Top module: `rds_bitbuf_top`

## Requirements
- R1: The buffer holds DEPTH (default 128) entries and delivers them in the order they were written.
- R2: A write into a full buffer with no read in the same cycle replaces the oldest entry and adds one to `drop_cnt`. The counter saturates at its all-ones value.
- R3: `{test_i,mode_i}` selects the mode: 2'b00 master (`sclk_oe`=1), 2'b01 slave (`sclk_oe`=0), 2'b10 standby and 2'b11 reserved. Standby and reserved behave the same way: no writes, no reads, stored entries kept, and `sclk_o`, `sdata_o`, `stat_o` and `sclk_oe` all 0.
- R4: In master mode, once armed and with the buffer non-empty, `sclk_o` is high for HALF_CYC cycles and then low for HALF_CYC cycles. One entry is taken on each rising edge, and `sdata_o` holds that entry's bit for the whole period, so the host samples it on the falling edge. With the buffer empty, `sclk_o` idles low.
- R5: In master mode, `stat_o` carries the reliability flag of the bit shown on `sdata_o` (1 = reliable).
- R6: In slave mode, `stat_o` is the ready flag: 1 exactly when the block is armed and the buffer is non-empty. While ready, `sdata_o` shows the oldest unread bit; otherwise it is 0.
- R7: In slave mode, `sclk_i` passes through a two-stage synchroniser. Each falling edge consumes one entry, and the outputs change on the third rising `clk` edge after `sclk_i` falls. A rising edge of `sclk_i` consumes nothing.
- R8: A `ch_rst` pulse disarms storage. In slave mode it also empties the buffer, so `stat_o` drops.
- R9: In master mode while not armed, `sclk_o` and `sdata_o` are held at 1 and `stat_o` at 0.
- R10: A strobed bit is stored only if `sig_det` is high in that cycle or has been high since the last reset. Once that has happened, bits are stored even after `sig_det` falls.
- R11: On a switch from master to slave, slave readout resumes with the entry after the last one shown in master mode.
- R12: `rst` empties the buffer, disarms storage and clears `drop_cnt` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| test_i | input | 1 | Mode select, upper bit |
| mode_i | input | 1 | Mode select, lower bit |
| ch_rst | input | 1 | Channel reset: disarms storage, and empties the buffer in slave mode |
| sig_det | input | 1 | Signal-present indication from the detector |
| bit_vld | input | 1 | One-cycle strobe for a decoded bit |
| bit_val | input | 1 | Decoded bit value |
| bit_rel | input | 1 | Reliability flag of the decoded bit |
| sclk_i | input | 1 | Serial clock from the host (slave mode) |
| sclk_o | output | 1 | Serial clock driven by the block (master mode) |
| sclk_oe | output | 1 | Drive enable for the serial clock line |
| sdata_o | output | 1 | Serial data |
| stat_o | output | 1 | Reliability flag (master) or ready flag (slave) |
| drop_cnt | output | DROP_W | Saturating count of entries lost to overwrite |

## Verification
A strobed bit reaches the buffer on the next rising edge, so `stat_o` reflects it one cycle later. The bench samples every output at the falling `clk` edge, half a cycle away from any update. A slave-clock fall changes the outputs on the third rising edge after it. The bench checks that the data is still unchanged after two rising edges and has changed after the third, and it waits four cycles per slave clock phase in every other case. In master mode the bench finds each rising edge of `sclk_o` by comparing consecutive falling-edge samples. At that point it reads the data and reliability, then counts the samples in which the clock stays high and compares the count with HALF_CYC.

// File: rtl/rds_buf_pkg.sv
package rds_buf_pkg;

    typedef enum logic [1:0] {
        OP_MASTER   = 2'd0,
        OP_SLAVE    = 2'd1,
        OP_STANDBY  = 2'd2,
        OP_RESERVED = 2'd3
    } op_mode_e;

    typedef enum logic [1:0] {
        MX_IDLE = 2'd0,
        MX_HIGH = 2'd1,
        MX_LOW  = 2'd2
    } mx_state_e;

    typedef struct packed {
        logic data;
        logic rel;
    } rds_bit_t;

    function automatic op_mode_e decode_op(input logic test, input logic mode);
        op_mode_e r;
        if (!test && !mode)     r = OP_MASTER;
        else if (!test && mode) r = OP_SLAVE;
        else if (test && !mode) r = OP_STANDBY;
        else                    r = OP_RESERVED;
        return r;
    endfunction

    function automatic logic op_active(input op_mode_e op);
        return (op == OP_MASTER) || (op == OP_SLAVE);
    endfunction

endpackage

// File: rtl/rds_bit_fifo.sv
module rds_bit_fifo
    import rds_buf_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          wr_en,
    input  rds_bit_t      wr_bit,
    input  logic          rd_en,
    output rds_bit_t      head,
    output logic [CW-1:0] fill,
    output logic          drop
);

    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] fill_q;
    rds_bit_t      mem [DEPTH];

    logic full;
    logic empty;
    logic do_rd;
    logic ovw;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (fill_q == CW'(DEPTH));
    assign empty = (fill_q == '0);
    assign do_rd = rd_en && !empty;
    assign ovw   = wr_en && full && !do_rd;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill_q <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (do_rd || ovw) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            if (wr_en && !do_rd && !full) begin
                fill_q <= fill_q + 1'b1;
            end else if (do_rd && !wr_en) begin
                fill_q <= fill_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_bit;
        end
    end

    assign head = mem[rd_ptr];
    assign fill = fill_q;
    assign drop = ovw;

endmodule

// File: rtl/rds_master_clk.sv
module rds_master_clk
    import rds_buf_pkg::*;
#(
    parameter int HALF_CYC = 16,
    localparam int HW = $clog2(HALF_CYC) + 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic avail,
    output logic pop,
    output logic sclk
);

    localparam logic [HW-1:0] LAST = HW'(HALF_CYC - 1);

    mx_state_e     st;
    logic [HW-1:0] cnt;

    always_comb begin
        pop = run && avail &&
              ((st == MX_IDLE) || ((st == MX_LOW) && (cnt == '0)));
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            st  <= MX_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                MX_IDLE: begin
                    if (pop) begin
                        st  <= MX_HIGH;
                        cnt <= LAST;
                    end
                end
                MX_HIGH: begin
                    if (cnt == '0) begin
                        st  <= MX_LOW;
                        cnt <= LAST;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                MX_LOW: begin
                    if (cnt == '0) begin
                        st  <= pop ? MX_HIGH : MX_IDLE;
                        cnt <= LAST;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    st  <= MX_IDLE;
                    cnt <= '0;
                end
            endcase
        end
    end

    assign sclk = (st == MX_HIGH);

endmodule

// File: rtl/rds_slave_sync.sv
module rds_slave_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    output logic fall
);

    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else begin
            sh <= {sh[STAGES-1:0], sclk_i};
        end
    end

    assign fall = sh[STAGES] && !sh[STAGES-1];

endmodule

// File: rtl/rds_bitbuf_top.sv
module rds_bitbuf_top
    import rds_buf_pkg::*;
#(
    parameter int DEPTH       = 128,
    parameter int HALF_CYC    = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DROP_W      = 8,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              test_i,
    input  logic              mode_i,
    input  logic              ch_rst,
    input  logic              sig_det,
    input  logic              bit_vld,
    input  logic              bit_val,
    input  logic              bit_rel,
    input  logic              sclk_i,
    output logic              sclk_o,
    output logic              sclk_oe,
    output logic              sdata_o,
    output logic              stat_o,
    output logic [DROP_W-1:0] drop_cnt
);

    op_mode_e          op;
    logic              armed_q;
    logic              wr_en;
    logic              flush;
    logic              ready;
    logic              m_run;
    logic              m_pop;
    logic              m_sclk;
    logic              s_fall;
    logic              s_pop;
    logic              drop;
    logic [CW-1:0]     fill;
    rds_bit_t          head;
    rds_bit_t          in_bit;
    rds_bit_t          m_cur;
    logic [DROP_W-1:0] drop_q;

    assign op = decode_op(test_i, mode_i);

    always_ff @(posedge clk) begin
        if (rst || ch_rst) begin
            armed_q <= 1'b0;
        end else if (sig_det) begin
            armed_q <= 1'b1;
        end
    end

    assign in_bit = '{data: bit_val, rel: bit_rel};
    assign wr_en  = bit_vld && (armed_q || sig_det) && op_active(op) && !ch_rst;
    assign flush  = ch_rst && (op == OP_SLAVE);
    assign ready  = armed_q && (fill != '0);
    assign m_run  = (op == OP_MASTER) && armed_q;
    assign s_pop  = (op == OP_SLAVE) && s_fall && ready;

    rds_bit_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .wr_en  (wr_en),
        .wr_bit (in_bit),
        .rd_en  (m_pop || s_pop),
        .head   (head),
        .fill   (fill),
        .drop   (drop)
    );

    rds_master_clk #(.HALF_CYC(HALF_CYC)) i_mclk (
        .clk   (clk),
        .rst   (rst),
        .run   (m_run),
        .avail (fill != '0),
        .pop   (m_pop),
        .sclk  (m_sclk)
    );

    rds_slave_sync #(.STAGES(SYNC_STAGES)) i_ssync (
        .clk    (clk),
        .rst    (rst),
        .sclk_i (sclk_i),
        .fall   (s_fall)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            m_cur <= '0;
        end else if (m_pop) begin
            m_cur <= head;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drop_q <= '0;
        end else if (drop && (drop_q != {DROP_W{1'b1}})) begin
            drop_q <= drop_q + 1'b1;
        end
    end

    always_comb begin
        sclk_o  = 1'b0;
        sclk_oe = 1'b0;
        sdata_o = 1'b0;
        stat_o  = 1'b0;
        case (op)
            OP_MASTER: begin
                sclk_oe = 1'b1;
                if (!armed_q) begin
                    sclk_o  = 1'b1;
                    sdata_o = 1'b1;
                end else begin
                    sclk_o  = m_sclk;
                    sdata_o = m_cur.data;
                    stat_o  = m_cur.rel;
                end
            end
            OP_SLAVE: begin
                stat_o  = ready;
                sdata_o = ready && head.data;
            end
            default: begin
                sclk_o = 1'b0;
            end
        endcase
    end

    assign drop_cnt = drop_q;

endmodule

// File: rtl/rds_bitbuf_chk.sv
module rds_bitbuf_chk
    import rds_buf_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input op_mode_e      op,
    input logic          armed,
    input logic          sig_det,
    input logic [CW-1:0] fill,
    input logic          sclk_o,
    input logic          sdata_o,
    input logic          stat_o
);

    // R1
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH));

    // R3
    standby_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        ((op == OP_STANDBY) || (op == OP_RESERVED)) |=> $stable(fill));

    // R9
    hold_high_chk: assert property (@(posedge clk) disable iff (rst)
        ((op == OP_MASTER) && !armed) |-> (sclk_o && sdata_o && !stat_o));

    // R10
    gate_store_chk: assert property (@(posedge clk) disable iff (rst)
        (!armed && !sig_det) |=> (fill <= $past(fill)));

    // R6
    ready_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ((op == OP_SLAVE) && stat_o) |-> (armed && (fill != '0)));

endmodule

bind rds_bitbuf_top rds_bitbuf_chk #(.DEPTH(DEPTH)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .armed   (armed_q),
    .sig_det (sig_det),
    .fill    (fill),
    .sclk_o  (sclk_o),
    .sdata_o (sdata_o),
    .stat_o  (stat_o)
);

// File: tb/test_rds_bitbuf_top.sv
`timescale 1ns/1ps
module test_rds_bitbuf_top;

    localparam int DEPTH = 128;
    localparam int HALF  = 4;
    localparam int NV    = 6;
    localparam logic [4:0]  VLEN [NV] = '{5'd1, 5'd5, 5'd8, 5'd12, 5'd16, 5'd3};
    localparam logic [15:0] VPAT [NV] = '{16'h0001, 16'h0015, 16'h00C3,
                                          16'h0A5E, 16'hB38D, 16'h0006};

    logic clk = 1'b0;
    logic rst, test_i, mode_i, ch_rst, sig_det, bit_vld, bit_val, bit_rel, sclk_i;
    logic sclk_o, sclk_oe, sdata_o, stat_o;
    logic [7:0] drop_cnt;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rds_bitbuf_top #(.DEPTH(DEPTH), .HALF_CYC(HALF)) i_rds_bitbuf_top (
        .clk(clk), .rst(rst), .test_i(test_i), .mode_i(mode_i), .ch_rst(ch_rst),
        .sig_det(sig_det), .bit_vld(bit_vld), .bit_val(bit_val), .bit_rel(bit_rel),
        .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sdata_o(sdata_o),
        .stat_o(stat_o), .drop_cnt(drop_cnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic b, input logic r);
        bit_vld = 1'b1;
        bit_val = b;
        bit_rel = r;
        tick(1);
        bit_vld = 1'b0;
    endtask

    task automatic slave_read(output logic d);
        d = sdata_o;
        sclk_i = 1'b1;
        tick(4);
        sclk_i = 1'b0;
        tick(4);
    endtask

    task automatic master_read(output logic d, output logic r, output int hc);
        logic prev;
        prev = sclk_o;
        hc = 0;
        d = 1'b0;
        r = 1'b0;
        for (int k = 0; k < 20 * HALF; k++) begin
            tick(1);
            if (!prev && sclk_o) break;
            prev = sclk_o;
        end
        d = sdata_o;
        r = stat_o;
        while (sclk_o && hc < 4 * HALF) begin
            hc++;
            tick(1);
        end
    endtask

    initial begin
        tick(150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic d, r;
        int hc, bad;

        rst = 1'b1; test_i = 1'b0; mode_i = 1'b1; ch_rst = 1'b0; sig_det = 1'b0;
        bit_vld = 1'b0; bit_val = 1'b0; bit_rel = 1'b0; sclk_i = 1'b0;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R12 reset state, R3 slave drive enable
        chk("R12 stat after reset", stat_o, 0);
        chk("R12 sdata after reset", sdata_o, 0);
        chk("R12 drop_cnt after reset", drop_cnt, 0);
        chk("R3 slave oe", sclk_oe, 0);

        // R10 gating on first detection
        push(1'b1, 1'b1); push(1'b1, 1'b1); push(1'b1, 1'b1);
        tick(1);
        chk("R10 nothing stored before detect", stat_o, 0);
        sig_det = 1'b1;
        push(1'b1, 1'b1);
        sig_det = 1'b0;
        push(1'b0, 1'b1);
        tick(1);
        chk("R10 ready after detect", stat_o, 1);
        slave_read(d);
        chk("R10 first stored bit", d, 1);
        slave_read(d);
        chk("R10 stored after detect dropped", d, 0);
        chk("R6 ready low when drained", stat_o, 0);

        // R1 R6 R7 vector table in slave mode
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < int'(VLEN[v]); i++) push(VPAT[v][i], 1'b0);
            tick(1);
            bad = 0;
            for (int i = 0; i < int'(VLEN[v]); i++) begin
                if (stat_o !== 1'b1) bad++;
                slave_read(d);
                if (d !== VPAT[v][i]) bad++;
            end
            chk($sformatf("R1 R7 vector %0d mismatches", v), bad, 0);
            chk($sformatf("R6 vector %0d ready after drain", v), stat_o, 0);
            chk($sformatf("R6 vector %0d data after drain", v), sdata_o, 0);
        end

        // R7 rising edge inert, falling edge latency
        push(1'b1, 1'b0); push(1'b0, 1'b0);
        tick(1);
        sclk_i = 1'b1;
        tick(5);
        chk("R7 rising edge consumes nothing", sdata_o, 1);
        sclk_i = 1'b0;
        tick(2);
        chk("R7 data held two edges after fall", sdata_o, 1);
        tick(1);
        chk("R7 data advanced on third edge", sdata_o, 0);
        tick(2);
        slave_read(d);
        chk("R7 drained", stat_o, 0);

        // R2 overwrite of oldest when full
        for (int i = 0; i < DEPTH + 2; i++) push((i % 3) == 0, 1'b0);
        tick(1);
        chk("R2 drop count", drop_cnt, 2);
        bad = 0;
        for (int i = 2; i < DEPTH + 2; i++) begin
            slave_read(d);
            if (d !== ((i % 3) == 0)) bad++;
        end
        chk("R2 R1 surviving order mismatches", bad, 0);
        chk("R2 drained after overflow", stat_o, 0);

        // R3 standby and reserved freeze the buffer
        push(1'b1, 1'b1);
        test_i = 1'b1; mode_i = 1'b0;
        tick(1);
        push(1'b0, 1'b0); push(1'b0, 1'b0);
        chk("R3 standby stat", stat_o, 0);
        chk("R3 standby sclk", sclk_o, 0);
        chk("R3 standby oe", sclk_oe, 0);
        chk("R3 standby sdata", sdata_o, 0);
        test_i = 1'b1; mode_i = 1'b1;
        tick(1);
        push(1'b0, 1'b0);
        chk("R3 reserved stat", stat_o, 0);
        test_i = 1'b0; mode_i = 1'b1;
        tick(1);
        chk("R3 entry kept through standby", stat_o, 1);
        slave_read(d);
        chk("R3 kept bit value", d, 1);
        chk("R3 nothing written in standby", stat_o, 0);

        // R8 channel reset in slave
        push(1'b1, 1'b1); push(1'b1, 1'b1);
        ch_rst = 1'b1;
        tick(1);
        ch_rst = 1'b0;
        tick(1);
        chk("R8 buffer emptied", stat_o, 0);
        push(1'b1, 1'b1);
        tick(1);
        chk("R8 disarmed after channel reset", stat_o, 0);

        // R9 master hold before detection
        mode_i = 1'b0;
        tick(2);
        chk("R9 sclk held high", sclk_o, 1);
        chk("R9 sdata held high", sdata_o, 1);
        chk("R9 stat low", stat_o, 0);
        chk("R3 master oe", sclk_oe, 1);

        // R4 R5 master readout
        sig_det = 1'b1;
        tick(1);
        sig_det = 1'b0;
        tick(2);
        chk("R4 idle low when empty", sclk_o, 0);
        mode_i = 1'b1;
        push(1'b1, 1'b0); push(1'b0, 1'b1); push(1'b1, 1'b1);
        mode_i = 1'b0;
        master_read(d, r, hc);
        chk("R4 bit0", d, 1);
        chk("R5 rel0", r, 0);
        chk("R4 high length", hc, HALF);
        master_read(d, r, hc);
        chk("R4 bit1", d, 0);
        chk("R5 rel1", r, 1);
        master_read(d, r, hc);
        chk("R4 bit2", d, 1);
        chk("R5 rel2", r, 1);
        bad = 0;
        for (int k = 0; k < 3 * HALF; k++) begin
            if (sclk_o !== 1'b0) bad++;
            tick(1);
        end
        chk("R4 clock idles when empty", bad, 0);

        // R11 master to slave continuity
        mode_i = 1'b1;
        push(1'b1, 1'b0); push(1'b1, 1'b0); push(1'b0, 1'b0); push(1'b1, 1'b0);
        mode_i = 1'b0;
        master_read(d, r, hc);
        master_read(d, r, hc);
        mode_i = 1'b1;
        tick(1);
        slave_read(d);
        chk("R11 third entry after switch", d, 0);
        slave_read(d);
        chk("R11 fourth entry after switch", d, 1);
        chk("R11 drained", stat_o, 0);

        // R12 system reset clears drop count
        rst = 1'b1;
        tick(1);
        rst = 1'b0;
        tick(1);
        chk("R12 drop_cnt cleared", drop_cnt, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule